// File: doc/BRIEF.md
# IO Page Translation Walker

This block maps a device DMA address onto a physical address by fetching one 64-bit translation entry from a table in memory. It takes four configuration inputs, all driven from configuration registers outside the block: a translation enable, a table base address, a 3-bit window-size code and a table-page-mode bit. The table-page-mode bit picks 8 KB or 64 KB granularity for indexing the table.

A DMA address arrives on a valid/ready request port, and the walker takes one request at a time. When translation is off, or the size code is not supported in the chosen mode, the walker answers at once and reads nothing from memory. Otherwise it computes the entry address and issues one read on a simple memory port. It then decodes the returned word and holds the response until the consumer accepts it.

The response carries three things. The first is the physical address, made of the physical page from the entry and the untranslated page offset of the DMA address. The second is a page-offset mask. The third is a 2-bit permission code.

Top module: `iopt_walker`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0 and mem_rd_valid is 0.
- R2: With cfg_enable at 0, the response has resp_paddr equal to the zero-extended DMA address, resp_mask 0x1FFF and resp_perm 2'b11 (read-write). No memory read is issued, whatever the size code and page mode are.
- R3: With cfg_big_table at 0 and size code c (0..7), the DMA address is first reduced modulo 2^(23+c). The walker then reads the entry at cfg_table_base + 8 * (reduced address >> 13). Address bits at or above the window do not change the entry address.
- R4: With cfg_big_table at 1 and size code c (0..5), the DMA address is first reduced modulo 2^(26+c). The walker then reads the entry at cfg_table_base + 8 * (reduced address >> 16).
- R5: With cfg_big_table at 1 and size code 6 or 7, the response has resp_perm 2'b00, resp_paddr 0 and resp_mask 0, and no memory read is issued.
- R6: The memory word is big-endian. Byte lane 0 (mem_resp_data[7:0]) is the most significant byte of the entry (entry bits 63:56), and lane 7 (bits 63:56) is the least significant.
- R7: An entry whose valid bit (bit 63) is 0 gives resp_perm 2'b00, resp_paddr 0 and resp_mask 0.
- R8: For a valid entry, the writable bit (bit 1) set gives resp_perm 2'b11, and clear gives 2'b01 (read-only). The code 2'b10 is never produced.
- R9: For a valid entry, the entry's page-size bit selects the page size; this is independent of cfg_big_table. With bit 61 set, resp_paddr is {entry[40:16], dma[15:0]} and resp_mask is 0xFFFF. With bit 61 clear, resp_paddr is {entry[40:13], dma[12:0]} and resp_mask is 0x1FFF.
- R10: From the accepted request until the response is accepted, req_ready stays 0 and no further request is taken.
- R11: While resp_valid is 1 and resp_ready is 0, resp_valid stays 1 and resp_paddr, resp_mask and resp_perm do not change.
- R12: While mem_rd_valid is 1 and mem_rd_ready is 0, mem_rd_valid stays 1 and mem_rd_addr does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Translation enable; 0 selects pass-through |
| cfg_table_base | input | 41 | Byte address of the translation table |
| cfg_size_code | input | 3 | DMA window size code |
| cfg_big_table | input | 1 | Table page mode: 0 = 8 KB indexing, 1 = 64 KB indexing |
| req_valid | input | 1 | DMA address request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_addr | input | DMA_AW (32) | DMA address to translate |
| resp_valid | output | 1 | Translation result valid |
| resp_ready | input | 1 | Consumer accepts the result |
| resp_paddr | output | 41 | Translated physical address |
| resp_mask | output | 16 | Page-offset mask |
| resp_perm | output | 2 | 00 none, 01 read-only, 11 read-write |
| mem_rd_valid | output | 1 | Entry read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 41 | Byte address of the entry |
| mem_resp_valid | input | 1 | Entry data valid |
| mem_resp_data | input | 64 | Entry bytes, lane i at bits 8i+7:8i |

## Verification
The assertions take the configuration inputs as steady for the whole life of a request. They also take it that memory returns exactly one mem_resp_valid pulse per accepted read, and never an unsolicited one. The stimulus changes configuration only while the walker is idle, and its memory model answers each accepted read with one data beat on the following cycle. The bench also stalls memory acceptance and response acceptance for several cycles to exercise the hold rules.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

    localparam int ENTRY_W         = 64;
    localparam int ENTRY_BYTES     = ENTRY_W / 8;
    localparam int ENT_LOG2        = $clog2(ENTRY_BYTES);
    localparam int PHYS_HI         = 40;
    localparam int PHYS_W          = PHYS_HI + 1;
    localparam int ENT_VALID_BIT   = 63;
    localparam int ENT_BIG_BIT     = 61;
    localparam int ENT_WR_BIT      = 1;
    localparam int SMALL_SHIFT     = 13;
    localparam int BIG_SHIFT       = 16;
    localparam int SMALL_WIN_LOG2  = 23;
    localparam int BIG_WIN_LOG2    = 26;
    localparam int NUM_CODES       = 8;
    localparam int BIG_CODES       = 6;
    localparam int MASK_W          = 16;

    localparam logic [MASK_W-1:0] SMALL_MASK = MASK_W'((1 << SMALL_SHIFT) - 1);
    localparam logic [MASK_W-1:0] BIG_MASK   = MASK_W'((1 << BIG_SHIFT) - 1);

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b11
    } perm_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        perm_e              perm;
        logic [PHYS_W-1:0]  paddr;
        logic [MASK_W-1:0]  mask;
    } xlate_res_t;

    // Lane 0 of the bus carries the most significant byte of the entry.
    function automatic logic [ENTRY_W-1:0] be_assemble(input logic [ENTRY_W-1:0] lanes);
        logic [ENTRY_W-1:0] w;
        w = '0;
        for (int i = 0; i < ENTRY_BYTES; i++) begin
            w[ENTRY_W-1-8*i -: 8] = lanes[8*i +: 8];
        end
        return w;
    endfunction

    function automatic xlate_res_t fault_res();
        xlate_res_t r;
        r.perm  = PERM_NONE;
        r.paddr = '0;
        r.mask  = '0;
        return r;
    endfunction

endpackage

// File: rtl/iopt_index.sv
module iopt_index
    import iopt_pkg::*;
#(
    parameter int DMA_AW = 32
) (
    input  logic [DMA_AW-1:0] addr,
    input  logic [2:0]        size_code,
    input  logic              big_table,
    input  logic [PHYS_W-1:0] table_base,
    output logic              unsupported,
    output logic [PHYS_W-1:0] ent_addr
);

    logic [DMA_AW-1:0] small_win [NUM_CODES];
    logic [DMA_AW-1:0] big_win   [NUM_CODES];
    logic [DMA_AW-1:0] sel_win;
    logic [DMA_AW-1:0] masked;
    logic [DMA_AW-1:0] page_num;

    // One window mask per size code, for each table page mode.
    for (genvar c = 0; c < NUM_CODES; c++) begin : g_win
        localparam int SW = SMALL_WIN_LOG2 + c;
        localparam int BW = BIG_WIN_LOG2 + c;
        assign small_win[c] = (SW >= DMA_AW) ? '1 : DMA_AW'((64'd1 << SW) - 64'd1);
        if (c < BIG_CODES) begin : g_big
            assign big_win[c] = (BW >= DMA_AW) ? '1 : DMA_AW'((64'd1 << BW) - 64'd1);
        end else begin : g_nobig
            assign big_win[c] = '0;
        end
    end

    always_comb begin
        sel_win     = big_table ? big_win[size_code] : small_win[size_code];
        masked      = addr & sel_win;
        page_num    = big_table ? (masked >> BIG_SHIFT) : (masked >> SMALL_SHIFT);
        unsupported = big_table && (size_code >= 3'(BIG_CODES));
        ent_addr    = table_base + (PHYS_W'(page_num) << ENT_LOG2);
    end

endmodule

// File: rtl/iopt_decode.sv
module iopt_decode
    import iopt_pkg::*;
#(
    parameter int DMA_AW = 32
) (
    input  logic [ENTRY_W-1:0] lanes,
    input  logic [DMA_AW-1:0]  addr,
    output xlate_res_t         res
);

    logic [ENTRY_W-1:0] entry;
    logic               unused_bits;

    assign entry = be_assemble(lanes);

    always_comb begin
        res = fault_res();
        if (entry[ENT_VALID_BIT]) begin
            res.perm = entry[ENT_WR_BIT] ? PERM_RW : PERM_RO;
            if (entry[ENT_BIG_BIT]) begin
                res.paddr = {entry[PHYS_HI:BIG_SHIFT], addr[BIG_SHIFT-1:0]};
                res.mask  = BIG_MASK;
            end else begin
                res.paddr = {entry[PHYS_HI:SMALL_SHIFT], addr[SMALL_SHIFT-1:0]};
                res.mask  = SMALL_MASK;
            end
        end
    end

    // Entry and address bits with no meaning for the result.
    assign unused_bits = ^{entry[62], entry[60:PHYS_HI+1], entry[SMALL_SHIFT-1:2],
                           entry[0], addr[DMA_AW-1:BIG_SHIFT]};

endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
    import iopt_pkg::*;
#(
    parameter int DMA_AW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_enable,
    input  logic [PHYS_W-1:0]    cfg_table_base,
    input  logic [2:0]           cfg_size_code,
    input  logic                 cfg_big_table,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [DMA_AW-1:0]    req_addr,
    output logic                 resp_valid,
    input  logic                 resp_ready,
    output logic [PHYS_W-1:0]    resp_paddr,
    output logic [MASK_W-1:0]    resp_mask,
    output logic [1:0]           resp_perm,
    output logic                 mem_rd_valid,
    input  logic                 mem_rd_ready,
    output logic [PHYS_W-1:0]    mem_rd_addr,
    input  logic                 mem_resp_valid,
    input  logic [ENTRY_W-1:0]   mem_resp_data
);

    walk_state_e        state_q;
    logic [DMA_AW-1:0]  addr_q;
    logic [PHYS_W-1:0]  ent_addr_q;
    xlate_res_t         res_q;

    logic               idx_unsup;
    logic [PHYS_W-1:0]  idx_addr;
    xlate_res_t         dec_res;
    xlate_res_t         pass_res;

    iopt_index #(.DMA_AW(DMA_AW)) u_index (
        .addr        (req_addr),
        .size_code   (cfg_size_code),
        .big_table   (cfg_big_table),
        .table_base  (cfg_table_base),
        .unsupported (idx_unsup),
        .ent_addr    (idx_addr)
    );

    iopt_decode #(.DMA_AW(DMA_AW)) u_decode (
        .lanes (mem_resp_data),
        .addr  (addr_q),
        .res   (dec_res)
    );

    always_comb begin
        pass_res.perm  = PERM_RW;
        pass_res.paddr = PHYS_W'(req_addr);
        pass_res.mask  = SMALL_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            ent_addr_q <= '0;
            res_q      <= fault_res();
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        if (!cfg_enable) begin
                            res_q   <= pass_res;
                            state_q <= ST_DONE;
                        end else if (idx_unsup) begin
                            res_q   <= fault_res();
                            state_q <= ST_DONE;
                        end else begin
                            ent_addr_q <= idx_addr;
                            state_q    <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (mem_rd_ready) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_resp_valid) begin
                        res_q   <= dec_res;
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (resp_ready) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (state_q == ST_IDLE);
    assign mem_rd_valid = (state_q == ST_ISSUE);
    assign mem_rd_addr  = ent_addr_q;
    assign resp_valid   = (state_q == ST_DONE);
    assign resp_paddr   = res_q.paddr;
    assign resp_mask    = res_q.mask;
    assign resp_perm    = res_q.perm;

endmodule

// File: rtl/iopt_walker_chk.sv
module iopt_walker_chk
    import iopt_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               resp_ready,
    input logic [PHYS_W-1:0]  resp_paddr,
    input logic [MASK_W-1:0]  resp_mask,
    input logic [1:0]         resp_perm,
    input logic               mem_rd_valid,
    input logic               mem_rd_ready,
    input logic [PHYS_W-1:0]  mem_rd_addr
);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !resp_valid && !mem_rd_valid));

    assert_fault_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_perm == 2'b00) |-> (resp_paddr == '0 && resp_mask == '0));

    assert_perm_code_R8: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_perm != 2'b10));

    assert_mask_shape_R9: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_perm != 2'b00) |-> (resp_mask == 16'h1FFF || resp_mask == 16'hFFFF));

    assert_single_req_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (resp_valid || mem_rd_valid) |-> !req_ready);

    assert_resp_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ready) |=>
            (resp_valid && $stable(resp_paddr) && $stable(resp_mask) && $stable(resp_perm)));

    assert_mem_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

endmodule

bind iopt_walker iopt_walker_chk u_chk (.*);

// File: tb/iopt_walker_test.sv
`timescale 1ns/1ps
module iopt_walker_test;
    import iopt_pkg::*;

    localparam int DMA_AW = 32;
    localparam logic [PHYS_W-1:0] TB_BASE = 41'h0_4000_0000;
    localparam int TBL_N = 1024;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cfg_enable = 1'b0;
    logic [PHYS_W-1:0]   cfg_table_base = TB_BASE;
    logic [2:0]          cfg_size_code = 3'd0;
    logic                cfg_big_table = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic [DMA_AW-1:0]   req_addr = '0;
    logic                resp_valid;
    logic                resp_ready = 1'b0;
    logic [PHYS_W-1:0]   resp_paddr;
    logic [MASK_W-1:0]   resp_mask;
    logic [1:0]          resp_perm;
    logic                mem_rd_valid;
    logic                mem_rd_ready;
    logic [PHYS_W-1:0]   mem_rd_addr;
    logic                mem_resp_valid = 1'b0;
    logic [ENTRY_W-1:0]  mem_resp_data = '0;

    logic                mem_gate = 1'b1;
    logic [63:0]         tbl [TBL_N];
    logic [PHYS_W-1:0]   last_rd_addr = '0;
    int                  reads = 0;
    int                  checks = 0;
    int                  errors = 0;
    bit                  done = 1'b0;

    logic [PHYS_W-1:0]   got_paddr;
    logic [MASK_W-1:0]   got_mask;
    logic [1:0]          got_perm;

    assign mem_rd_ready = mem_gate;

    always #2 clk = ~clk;

    iopt_walker #(.DMA_AW(DMA_AW)) uut (.*);

    // Memory holding big-endian entries: lane 0 returns the most significant byte.
    function automatic logic [63:0] to_lanes(input logic [63:0] e);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = e[63-8*i -: 8];
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_resp_valid <= 1'b0;
        end else begin
            mem_resp_valid <= 1'b0;
            if (mem_rd_valid && mem_rd_ready) begin
                logic [PHYS_W-1:0] off;
                off = mem_rd_addr - TB_BASE;
                mem_resp_valid <= 1'b1;
                mem_resp_data  <= (off < PHYS_W'(TBL_N * 8)) ? to_lanes(tbl[off[12:3]]) : 64'h0;
                last_rd_addr   <= mem_rd_addr;
                reads          <= reads + 1;
            end
        end
    end

    // Expected values derived from the requirements.
    function automatic int exp_index(input logic [31:0] a, input logic big, input int code);
        logic [63:0] m;
        int w;
        w = big ? (26 + code) : (23 + code);
        m = {32'h0, a} & ((64'd1 << w) - 64'd1);
        return int'(big ? (m >> 16) : (m >> 13));
    endfunction

    function automatic logic [63:0] mk_small(input logic v, input logic wr, input logic [27:0] pg);
        logic [63:0] e;
        e = '0; e[63] = v; e[61] = 1'b0; e[1] = wr; e[40:13] = pg;
        return e;
    endfunction

    function automatic logic [63:0] mk_big(input logic v, input logic wr, input logic [24:0] pg);
        logic [63:0] e;
        e = '0; e[63] = v; e[61] = 1'b1; e[1] = wr; e[40:16] = pg;
        return e;
    endfunction

    function automatic logic [PHYS_W-1:0] exp_paddr(input logic [63:0] e, input logic [31:0] a);
        return e[61] ? {e[40:16], a[15:0]} : {e[40:13], a[12:0]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic en, input logic big, input logic [2:0] code);
        @(negedge clk);
        cfg_enable = en; cfg_big_table = big; cfg_size_code = code;
    endtask

    task automatic issue(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic collect();
        while (!resp_valid) @(negedge clk);
        got_paddr = resp_paddr; got_mask = resp_mask; got_perm = resp_perm;
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] a);
        issue(a);
        collect();
    endtask

    // Translated lookup with expected entry address and result.
    task automatic run_lookup(input string tag, input logic big, input int code,
                              input logic [31:0] a, input logic [63:0] e);
        int idx;
        int r0;
        idx = exp_index(a, big, code);
        tbl[idx] = e;
        set_cfg(1'b1, big, 3'(code));
        r0 = reads;
        xlate(a);
        chk({tag, " one read"}, 64'(reads - r0), 64'd1);
        chk({tag, " entry addr"}, 64'(last_rd_addr), 64'(TB_BASE + PHYS_W'(idx * 8)));
        if (e[63]) begin
            chk({tag, " paddr R9"}, 64'(got_paddr), 64'(exp_paddr(e, a)));
            chk({tag, " mask R9"}, 64'(got_mask), e[61] ? 64'hFFFF : 64'h1FFF);
            chk({tag, " perm R8"}, 64'(got_perm), e[1] ? 64'd3 : 64'd1);
        end else begin
            chk({tag, " perm R7"}, 64'(got_perm), 64'd0);
            chk({tag, " paddr R7"}, 64'(got_paddr), 64'd0);
            chk({tag, " mask R7"}, 64'(got_mask), 64'd0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        chk("R1 resp_valid", 64'(resp_valid), 64'd0);
        chk("R1 mem_rd_valid", 64'(mem_rd_valid), 64'd0);
    endtask

    task automatic t_passthrough();
        int r0;
        set_cfg(1'b0, 1'b0, 3'd0);
        r0 = reads;
        xlate(32'hDEAD_BEEF);
        chk("R2 paddr", 64'(got_paddr), 64'h0_DEAD_BEEF);
        chk("R2 mask", 64'(got_mask), 64'h1FFF);
        chk("R2 perm", 64'(got_perm), 64'd3);
        set_cfg(1'b0, 1'b1, 3'd7);
        xlate(32'h0000_1234);
        chk("R2 paddr big/7", 64'(got_paddr), 64'h1234);
        chk("R2 perm big/7", 64'(got_perm), 64'd3);
        chk("R2 no read", 64'(reads - r0), 64'd0);
    endtask

    task automatic t_small_index();
        run_lookup("R3 code0 high bits", 1'b0, 0, 32'hFF80_A123, mk_small(1'b1, 1'b1, 28'h0ABCDE1));
        run_lookup("R3 code7", 1'b0, 7, 32'h4057_9ABC, mk_small(1'b1, 1'b1, 28'h5550001));
        run_lookup("R3 code3", 1'b0, 3, 32'h0003_2FFF, mk_small(1'b1, 1'b1, 28'h0000777));
    endtask

    task automatic t_big_index();
        run_lookup("R4 code0", 1'b1, 0, 32'hFC09_BEEF, mk_big(1'b1, 1'b1, 25'h1234567));
        run_lookup("R4 code5", 1'b1, 5, 32'h83E8_0042, mk_big(1'b1, 1'b1, 25'h0000ABC));
        run_lookup("R4 R9 small page", 1'b1, 3, 32'hE003_0345, mk_small(1'b1, 1'b1, 28'hFEDCBA9));
    endtask

    task automatic t_unsupported();
        int r0;
        for (int code = 6; code < 8; code++) begin
            set_cfg(1'b1, 1'b1, 3'(code));
            r0 = reads;
            xlate(32'h0001_0000);
            chk("R5 perm", 64'(got_perm), 64'd0);
            chk("R5 paddr", 64'(got_paddr), 64'd0);
            chk("R5 mask", 64'(got_mask), 64'd0);
            chk("R5 no read", 64'(reads - r0), 64'd0);
        end
    endtask

    task automatic t_entry_bits();
        logic [63:0] e;
        e = mk_small(1'b0, 1'b1, 28'h1111111);
        run_lookup("R7 invalid", 1'b0, 1, 32'h0000_4000 | (32'd20 << 13), e);
        run_lookup("R8 read-only small", 1'b0, 2, (32'd30 << 13) | 32'h0055, mk_small(1'b1, 1'b0, 28'h0200000));
        run_lookup("R8 read-only big", 1'b1, 1, (32'd31 << 16) | 32'h9999, mk_big(1'b1, 1'b0, 25'h1FFFFFF));
    endtask

    task automatic t_endian();
        logic [63:0] e;
        logic [31:0] a;
        e = 64'h8000_0123_4567_E002;
        a = (32'd12 << 13) | 32'h0777;
        tbl[12] = e;
        set_cfg(1'b1, 1'b0, 3'd2);
        xlate(a);
        chk("R6 paddr", 64'(got_paddr), 64'(exp_paddr(e, a)));
        chk("R6 perm", 64'(got_perm), 64'd3);
    endtask

    task automatic t_backpressure();
        logic [PHYS_W-1:0] p0;
        int r0;
        tbl[40] = mk_small(1'b1, 1'b1, 28'h00C0FFE);
        set_cfg(1'b1, 1'b0, 3'd0);
        issue(32'd40 << 13);
        while (!resp_valid) @(negedge clk);
        p0 = resp_paddr;
        r0 = reads;
        req_valid = 1'b1; req_addr = 32'd41 << 13;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R11 resp held", 64'(resp_valid), 64'd1);
            chk("R11 paddr stable", 64'(resp_paddr), 64'(p0));
            chk("R10 req_ready low", 64'(req_ready), 64'd0);
        end
        chk("R10 no second read", 64'(reads - r0), 64'd0);
        req_valid = 1'b0;
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        chk("R10 ready after accept", 64'(req_ready), 64'd1);
        chk("R11 paddr value", 64'(p0), 64'(exp_paddr(tbl[40], 32'd40 << 13)));
    endtask

    task automatic t_mem_stall();
        logic [PHYS_W-1:0] a0;
        tbl[50] = mk_big(1'b1, 1'b1, 25'h0AAAAAA);
        set_cfg(1'b1, 1'b1, 3'd1);
        mem_gate = 1'b0;
        issue((32'd50 << 16) | 32'h1357);
        a0 = mem_rd_addr;
        chk("R12 entry addr", 64'(a0), 64'(TB_BASE + 41'd400));
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R12 rd held", 64'(mem_rd_valid), 64'd1);
            chk("R12 addr stable", 64'(mem_rd_addr), 64'(a0));
        end
        mem_gate = 1'b1;
        collect();
        chk("R12 result after stall", 64'(got_paddr), 64'(exp_paddr(tbl[50], (32'd50 << 16) | 32'h1357)));
    endtask

    initial begin
        for (int i = 0; i < TBL_N; i++) tbl[i] = 64'h0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_passthrough();
        t_small_index();
        t_big_index();
        t_unsupported();
        t_entry_bits();
        t_endian();
        t_backpressure();
        t_mem_stall();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule